// File: doc/BRIEF.md
# Windowed Spectral Peak and Phase Estimator

This block sits behind an FFT in a burst receiver. It takes the complex output bins of one burst as a stream, one bin per valid cycle, with a flag on the final bin. While the bins stream past, it keeps the index, squared magnitude and complex value of the strongest bin seen so far. Bins outside a configurable search window are skipped. The window is the union of a low band starting at bin 0 and a high band ending at bin N−1. Once the final bin has arrived, the block runs a small iterative angle-only CORDIC on the stored winning value, exactly once per burst. It divides the resulting angle by the modulation order M and presents the peak index and the phase estimate, together with a one-cycle done strobe.

The frequency correction stage downstream uses the peak index as its frequency estimate and the phase output as its phase estimate. Angles use binary scaling: the value 2^(ANG_W−1) stands for π radians. M is a power of two and is selected by a two-bit code.

Top module: `spec_peak_phase`

## Requirements
- R1: The bin index counts valid bins from 0 since the previous final bin. The reported peak index is the index of the candidate bin with the largest re²+im².
- R2: When several candidate bins share the largest magnitude, the lowest index among them is reported.
- R3: With `win_en`=1, a bin k is a candidate only if k ≤ `win_hi` or k ≥ `win_lo`. A larger bin outside the window does not change the result.
- R4: With `win_en`=0, or with `win_hi`=N/2 and `win_lo`=N/2−1, every bin 0..N−1 is a candidate.
- R5: Bins with index ≥ `fft_n` (N) are never candidates, even when the burst carries more bins.
- R6: `phase` equals atan2(im, re) of the winning bin, scaled so that 2^(ANG_W−1) is π, then arithmetically shifted right by `mod_log2`. The error is at most 40 LSB modulo 2^ANG_W/M.
- R7: When the winning bin value is exactly zero, `phase` is 0.
- R8: `done` is high for exactly one cycle, ITER+2 clock edges after the edge that accepts the final bin.
- R9: After reset, `done`, `peak_idx` and `phase` are 0. `peak_idx` and `phase` change only in the cycle where `done` is high and hold otherwise.
- R10: `mod_log2` codes 0, 1, 2 and 3 select M = 1, 2, 4 and 8. It is sampled one cycle after the final bin and must be held from the final bin until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_vld | input | 1 | A bin is present this cycle |
| bin_last | input | 1 | The present bin is the last of the burst |
| bin_re | input | DW | Signed real part of the bin |
| bin_im | input | DW | Signed imaginary part of the bin |
| win_en | input | 1 | Enable the search window |
| win_hi | input | IDX_W | Last index of the low band |
| win_lo | input | IDX_W | First index of the high band |
| fft_n | input | IDX_W+1 | Number of FFT points N |
| mod_log2 | input | 2 | log2 of the modulation order M |
| peak_idx | output | IDX_W | Index of the winning bin |
| phase | output | ANG_W | Signed phase estimate |
| done | output | 1 | One-cycle result strobe |

## Verification
A wrong comparison or a skipped window test in the running maximum only shows up when the burst ends. It appears as a wrong `peak_idx` on the next `done`, ITER+2 cycles after the final bin. A stale best value or a wrongly cleared best value appears in the same way, but on the following burst. Faults in the angle iterations show up only as a `phase` error at that same strobe. A step count off by one shows up at once as a `done` that arrives one cycle early or late. The sweeps place the peak at every bin position, at angles spread around the circle, and with every M. This makes each of these faults visible within one burst.

// File: rtl/spec_peak_phase_pkg.sv
package spec_peak_phase_pkg;

   // atan(2^-i) with pi == 32768, rounded
   function automatic int atan_q16(input int i);
      case (i)
         0:       return 8192;
         1:       return 4836;
         2:       return 2555;
         3:       return 1297;
         4:       return 651;
         5:       return 326;
         6:       return 163;
         7:       return 81;
         8:       return 41;
         9:       return 20;
         10:      return 10;
         11:      return 5;
         12:      return 3;
         13:      return 1;
         14:      return 1;
         default: return 0;
      endcase
   endfunction

   typedef enum logic {CO_IDLE, CO_RUN} cordic_st_t;

endpackage

// File: rtl/spp_window.sv
module spp_window #(
   parameter int IDX_W      = 4,
   parameter bit HAS_WINDOW = 1'b1
) (
   input  logic [IDX_W:0]   idx,
   input  logic             win_en,
   input  logic [IDX_W-1:0] win_hi,
   input  logic [IDX_W-1:0] win_lo,
   output logic             in_win
);
   generate
      if (HAS_WINDOW) begin : g_win
         assign in_win = !win_en
                      || (idx <= {1'b0, win_hi})
                      || (idx >= {1'b0, win_lo});
      end else begin : g_nowin
         logic unused_win;
         assign unused_win = ^{idx, win_en, win_hi, win_lo};
         assign in_win     = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/spp_peak_track.sv
module spp_peak_track #(
   parameter int DW    = 8,
   parameter int IDX_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bin_vld,
   input  logic                 bin_last,
   input  logic signed [DW-1:0] bin_re,
   input  logic signed [DW-1:0] bin_im,
   input  logic                 in_win,
   input  logic [IDX_W:0]       fft_n,
   output logic [IDX_W:0]       cnt,
   output logic                 fin_vld,
   output logic [IDX_W-1:0]     fin_idx,
   output logic signed [DW-1:0] fin_re,
   output logic signed [DW-1:0] fin_im
);
   localparam int MW = 2 * DW + 1;

   logic [IDX_W:0]          cnt_q;
   logic                    have_q;
   logic signed [MW-1:0]    best_mag_q;
   logic [IDX_W-1:0]        best_idx_q;
   logic signed [DW-1:0]    best_re_q, best_im_q;

   logic signed [MW-1:0]    re_x, im_x, mag;
   logic                    cand, take;
   logic signed [MW-1:0]    nxt_mag;
   logic [IDX_W-1:0]        nxt_idx;
   logic signed [DW-1:0]    nxt_re, nxt_im;

   assign re_x = MW'(bin_re);
   assign im_x = MW'(bin_im);
   assign mag  = re_x * re_x + im_x * im_x;

   assign cand = in_win && (cnt_q < fft_n);
   // strict compare: an equal later bin never replaces the earlier one
   assign take = bin_vld && cand && (!have_q || (mag > best_mag_q));

   assign nxt_mag = take ? mag                    : best_mag_q;
   assign nxt_idx = take ? cnt_q[IDX_W-1:0]       : best_idx_q;
   assign nxt_re  = take ? bin_re                 : best_re_q;
   assign nxt_im  = take ? bin_im                 : best_im_q;
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         have_q     <= 1'b0;
         best_mag_q <= '0;
         best_idx_q <= '0;
         best_re_q  <= '0;
         best_im_q  <= '0;
         fin_vld    <= 1'b0;
         fin_idx    <= '0;
         fin_re     <= '0;
         fin_im     <= '0;
      end else begin
         fin_vld <= 1'b0;
         if (bin_vld) begin
            if (bin_last) begin
               fin_vld    <= 1'b1;
               fin_idx    <= nxt_idx;
               fin_re     <= nxt_re;
               fin_im     <= nxt_im;
               cnt_q      <= '0;
               have_q     <= 1'b0;
               best_mag_q <= '0;
               best_idx_q <= '0;
               best_re_q  <= '0;
               best_im_q  <= '0;
            end else begin
               cnt_q      <= (&cnt_q) ? cnt_q : cnt_q + 1'b1;
               have_q     <= have_q | take;
               best_mag_q <= nxt_mag;
               best_idx_q <= nxt_idx;
               best_re_q  <= nxt_re;
               best_im_q  <= nxt_im;
            end
         end
      end
   end
endmodule

// File: rtl/spp_cordic_angle.sv
module spp_cordic_angle #(
   parameter int DW    = 8,
   parameter int ANG_W = 16,
   parameter int ITER  = 12,
   parameter int GUARD = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [DW-1:0]    x_in,
   input  logic signed [DW-1:0]    y_in,
   output logic                    ang_vld,
   output logic signed [ANG_W-1:0] ang
);
   import spec_peak_phase_pkg::*;

   localparam int XW   = DW + 2 + GUARD;
   localparam int IT_W = $clog2(ITER + 1);
   localparam logic signed [ANG_W-1:0] QTR = {2'b01, {(ANG_W-2){1'b0}}};

   cordic_st_t              st_q;
   logic [IT_W-1:0]         it_q;
   logic signed [XW-1:0]    x_q, y_q;
   logic signed [ANG_W-1:0] z_q;

   logic signed [XW-1:0]    xe, ye, x0, y0, xs, ys, x_nx, y_nx;
   logic signed [ANG_W-1:0] z0, step, z_nx;

   // move the vector into the right half plane
   always_comb begin
      xe = XW'(x_in) <<< GUARD;
      ye = XW'(y_in) <<< GUARD;
      if (xe < 0) begin
         if (ye >= 0) begin
            x0 = ye;  y0 = -xe; z0 = QTR;
         end else begin
            x0 = -ye; y0 = xe;  z0 = -QTR;
         end
      end else begin
         x0 = xe; y0 = ye; z0 = '0;
      end
   end

   assign xs   = x_q >>> it_q;
   assign ys   = y_q >>> it_q;
   assign step = ANG_W'(atan_q16(int'(it_q)) >>> (16 - ANG_W));

   always_comb begin
      if (y_q >= 0) begin
         x_nx = x_q + ys; y_nx = y_q - xs; z_nx = z_q + step;
      end else begin
         x_nx = x_q - ys; y_nx = y_q + xs; z_nx = z_q - step;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= CO_IDLE;
         it_q    <= '0;
         x_q     <= '0;
         y_q     <= '0;
         z_q     <= '0;
         ang_vld <= 1'b0;
         ang     <= '0;
      end else begin
         ang_vld <= 1'b0;
         case (st_q)
            CO_IDLE: if (start) begin
               x_q  <= x0;
               y_q  <= y0;
               z_q  <= z0;
               it_q <= '0;
               st_q <= CO_RUN;
            end
            default: begin
               x_q <= x_nx;
               y_q <= y_nx;
               z_q <= z_nx;
               if (it_q == IT_W'(ITER - 1)) begin
                  st_q    <= CO_IDLE;
                  ang_vld <= 1'b1;
                  ang     <= z_nx;
               end else begin
                  it_q <= it_q + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/spec_peak_phase.sv
module spec_peak_phase #(
   parameter int DW         = 8,
   parameter int IDX_W      = 4,
   parameter int ANG_W      = 16,
   parameter int ITER       = 12,
   parameter int GUARD      = 4,
   parameter bit HAS_WINDOW = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bin_vld,
   input  logic                    bin_last,
   input  logic signed [DW-1:0]    bin_re,
   input  logic signed [DW-1:0]    bin_im,
   input  logic                    win_en,
   input  logic [IDX_W-1:0]        win_hi,
   input  logic [IDX_W-1:0]        win_lo,
   input  logic [IDX_W:0]          fft_n,
   input  logic [1:0]              mod_log2,
   output logic [IDX_W-1:0]        peak_idx,
   output logic signed [ANG_W-1:0] phase,
   output logic                    done
);
   generate
      if (DW < 4 || DW > 16)           begin : g_bad_dw  $error("DW out of range");    end
      if (IDX_W < 2 || IDX_W > 12)     begin : g_bad_idx $error("IDX_W out of range"); end
      if (ANG_W < 8 || ANG_W > 16)     begin : g_bad_ang $error("ANG_W out of range"); end
      if (ITER < 4 || ITER > ANG_W)    begin : g_bad_it  $error("ITER out of range");  end
      if (GUARD < 0 || GUARD > 8)      begin : g_bad_gd  $error("GUARD out of range"); end
   endgenerate

   logic [IDX_W:0]          cnt;
   logic                    in_win;
   logic                    fin_vld;
   logic [IDX_W-1:0]        fin_idx;
   logic signed [DW-1:0]    fin_re, fin_im;
   logic                    ang_vld;
   logic signed [ANG_W-1:0] ang;

   logic [IDX_W-1:0]        idx_hold;
   logic                    zero_hold;
   logic [1:0]              mod_hold;

   spp_window #(.IDX_W(IDX_W), .HAS_WINDOW(HAS_WINDOW)) i_window (
      .idx(cnt), .win_en(win_en), .win_hi(win_hi), .win_lo(win_lo), .in_win(in_win)
   );

   spp_peak_track #(.DW(DW), .IDX_W(IDX_W)) i_track (
      .clk(clk), .rst_n(rst_n), .bin_vld(bin_vld), .bin_last(bin_last),
      .bin_re(bin_re), .bin_im(bin_im), .in_win(in_win), .fft_n(fft_n),
      .cnt(cnt), .fin_vld(fin_vld), .fin_idx(fin_idx),
      .fin_re(fin_re), .fin_im(fin_im)
   );

   spp_cordic_angle #(.DW(DW), .ANG_W(ANG_W), .ITER(ITER), .GUARD(GUARD)) i_cordic (
      .clk(clk), .rst_n(rst_n), .start(fin_vld), .x_in(fin_re), .y_in(fin_im),
      .ang_vld(ang_vld), .ang(ang)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_hold  <= '0;
         zero_hold <= 1'b0;
         mod_hold  <= '0;
         done      <= 1'b0;
         peak_idx  <= '0;
         phase     <= '0;
      end else begin
         if (fin_vld) begin
            idx_hold  <= fin_idx;
            zero_hold <= (fin_re == '0) && (fin_im == '0);
            mod_hold  <= mod_log2;
         end
         done <= ang_vld;
         if (ang_vld) begin
            peak_idx <= idx_hold;
            phase    <= zero_hold ? '0 : (ang >>> mod_hold);
         end
      end
   end
endmodule

// File: rtl/spp_checker.sv
module spp_checker #(
   parameter int IDX_W = 4,
   parameter int ANG_W = 16,
   parameter int ITER  = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bin_vld,
   input logic                    bin_last,
   input logic                    fin_vld,
   input logic                    zero_hold,
   input logic                    done,
   input logic [IDX_W-1:0]        peak_idx,
   input logic signed [ANG_W-1:0] phase
);
   localparam int LW = $clog2(ITER + 4) + 1;

   logic [LW-1:0] lat_q;
   logic          active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q    <= '0;
         active_q <= 1'b0;
      end else if (bin_vld && bin_last) begin
         lat_q    <= '0;
         active_q <= 1'b1;
      end else if (active_q) begin
         lat_q <= lat_q + 1'b1;
         if (lat_q == LW'(ITER + 2)) active_q <= 1'b0;
      end
   end

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (active_q && lat_q == LW'(ITER + 2)));                   // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                  // R8
   AST_TRACK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_vld && bin_last) |=> fin_vld);                               // R1
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(peak_idx) && $stable(phase)));                 // R9
   AST_ZERO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && zero_hold) |-> (phase == '0));                           // R7
endmodule

bind spec_peak_phase spp_checker #(.IDX_W(IDX_W), .ANG_W(ANG_W), .ITER(ITER)) i_chk (
   .clk(clk), .rst_n(rst_n), .bin_vld(bin_vld), .bin_last(bin_last),
   .fin_vld(fin_vld), .zero_hold(zero_hold), .done(done),
   .peak_idx(peak_idx), .phase(phase)
);

// File: tb/test_spec_peak_phase.sv
module test_spec_peak_phase;
   localparam int DW    = 8;
   localparam int IDX_W = 4;
   localparam int ANG_W = 16;
   localparam int ITER  = 12;
   localparam real PI   = 3.14159265358979;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    bin_vld = 1'b0, bin_last = 1'b0;
   logic signed [DW-1:0]    bin_re = '0, bin_im = '0;
   logic                    win_en = 1'b0;
   logic [IDX_W-1:0]        win_hi = '0, win_lo = '0;
   logic [IDX_W:0]          fft_n = 5'd16;
   logic [1:0]              mod_log2 = 2'd0;
   logic [IDX_W-1:0]        peak_idx;
   logic signed [ANG_W-1:0] phase;
   logic                    done;

   int checks = 0;
   int errors = 0;
   int seed   = 7;
   int di [0:31];
   int dq [0:31];

   always #4 clk = ~clk;   // 125 MHz

   spec_peak_phase #(.DW(DW), .IDX_W(IDX_W), .ANG_W(ANG_W), .ITER(ITER)) i_spec_peak_phase (
      .clk(clk), .rst_n(rst_n), .bin_vld(bin_vld), .bin_last(bin_last),
      .bin_re(bin_re), .bin_im(bin_im), .win_en(win_en), .win_hi(win_hi),
      .win_lo(win_lo), .fft_n(fft_n), .mod_log2(mod_log2),
      .peak_idx(peak_idx), .phase(phase), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int rnd(input int lo, input int hi);
      seed = seed * 1103515245 + 12345;
      return lo + int'((seed >>> 16) & 32'h7fff) % (hi - lo + 1);
   endfunction

   task automatic run_burst(input int nb, input bit wen, input int whi, input int wlo,
                            input int fn, input int m, input string tg);
      int  best = -1;
      int  bm   = 0;
      int  seen = -1;
      int  npulse = 0;
      int  prev_idx, prev_ph, got_idx, got_ph;
      real ex, per, d;
      for (int k = 0; k < nb; k++) begin
         int mg = di[k] * di[k] + dq[k] * dq[k];
         bit cand = (k < fn) && (!wen || k <= whi || k >= wlo);
         if (cand && (best < 0 || mg > bm)) begin best = k; bm = mg; end
      end
      @(negedge clk);
      prev_idx = int'(peak_idx);
      prev_ph  = int'(phase);
      win_en = wen; win_hi = IDX_W'(whi); win_lo = IDX_W'(wlo);
      fft_n = 5'(fn); mod_log2 = 2'(m);
      for (int k = 0; k < nb; k++) begin
         if (k > 0) @(negedge clk);
         bin_vld = 1'b1; bin_re = DW'(di[k]); bin_im = DW'(dq[k]);
         bin_last = (k == nb - 1);
      end
      got_idx = 0; got_ph = 0;
      for (int j = 0; j < ITER + 6; j++) begin
         @(negedge clk);
         bin_vld = 1'b0; bin_last = 1'b0;
         if (j == 0) begin
            chk(int'(peak_idx) == prev_idx, "R9 idx hold", int'(peak_idx), prev_idx);
            chk(int'(phase) == prev_ph, "R9 phase hold", int'(phase), prev_ph);
         end
         if (done) begin
            npulse++;
            if (seen < 0) begin
               seen = j; got_idx = int'(peak_idx); got_ph = int'(phase);
            end
         end
      end
      chk(seen == ITER + 2, "R8 latency", seen, ITER + 2);
      chk(npulse == 1, "R8 single pulse", npulse, 1);
      if (best < 0) best = 0;
      chk(got_idx == best, tg, got_idx, best);
      if (di[best] == 0 && dq[best] == 0) begin
         chk(got_ph == 0, "R7 zero phase", got_ph, 0);
      end else begin
         ex  = $atan2(real'(dq[best]), real'(di[best])) * 32768.0 / PI / (2.0 ** m);
         per = 65536.0 / (2.0 ** m);
         d   = real'(got_ph) - ex;
         while (d >  per / 2.0) d = d - per;
         while (d < -per / 2.0) d = d + per;
         chk(d <= 40.0 && d >= -40.0, (m == 0) ? "R6 phase" : "R10 phase/M",
             got_ph, int'(ex));
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R9 reset done", int'(done), 0);
      chk(peak_idx == '0, "R9 reset idx", int'(peak_idx), 0);
      chk(phase == '0, "R9 reset phase", int'(phase), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1/R6/R10: single peak at every position, angles around the circle
      for (int p = 0; p < 16; p++) begin
         real th = (-165.0 + 21.0 * p) * PI / 180.0;
         for (int k = 0; k < 16; k++) begin di[k] = rnd(-3, 3); dq[k] = rnd(-3, 3); end
         di[p] = int'($rtoi(100.0 * $cos(th) + ((100.0 * $cos(th) >= 0) ? 0.5 : -0.5)));
         dq[p] = int'($rtoi(100.0 * $sin(th) + ((100.0 * $sin(th) >= 0) ? 0.5 : -0.5)));
         run_burst(16, 1'b0, 0, 0, 16, p % 4, "R1 peak index");
      end

      // R2: equal magnitudes, first candidate wins
      for (int k = 0; k < 16; k++) begin di[k] = 1; dq[k] = 0; end
      di[3] = 30; dq[3] = 40; di[6] = 40; dq[6] = -30; di[11] = -50; dq[11] = 0;
      run_burst(16, 1'b0, 0, 0, 16, 0, "R2 tie lowest");
      run_burst(16, 1'b1, 2, 5, 16, 1, "R2 tie in window");

      // R3: random data, random windows
      for (int t = 0; t < 30; t++) begin
         for (int k = 0; k < 16; k++) begin di[k] = rnd(-100, 100); dq[k] = rnd(-100, 100); end
         run_burst(16, 1'b1, rnd(0, 7), rnd(8, 15), 16, rnd(0, 3), "R3 window");
      end
      for (int k = 0; k < 16; k++) begin di[k] = 2; dq[k] = 2; end
      di[7] = 120; dq[7] = 10; di[2] = -20; dq[2] = 25;
      run_burst(16, 1'b1, 3, 12, 16, 0, "R3 outside ignored");

      // R4: unwindowed equivalents
      for (int t = 0; t < 8; t++) begin
         for (int k = 0; k < 16; k++) begin di[k] = rnd(-100, 100); dq[k] = rnd(-100, 100); end
         run_burst(16, 1'b1, 8, 7, 16, 0, "R4 full window");
         run_burst(16, 1'b0, 0, 0, 16, 2, "R4 window off");
      end

      // R5: bins beyond N ignored
      for (int k = 0; k < 12; k++) begin di[k] = rnd(-10, 10); dq[k] = rnd(-10, 10); end
      di[10] = 127; dq[10] = -60; di[5] = 40; dq[5] = 40;
      run_burst(12, 1'b0, 0, 0, 8, 0, "R5 beyond N");
      for (int k = 0; k < 8; k++) begin di[k] = rnd(-100, 100); dq[k] = rnd(-100, 100); end
      run_burst(8, 1'b1, 2, 6, 8, 3, "R5 N=8 window");

      // R7: all-zero burst
      for (int k = 0; k < 16; k++) begin di[k] = 0; dq[k] = 0; end
      run_burst(16, 1'b0, 0, 0, 16, 1, "R7 zero index");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule